// File: doc/BRIEF.md
# Four-Lane Polyphase Low-Pass Decimator by Three

This block takes a stream of signed 16-bit samples that arrives four per clock, the product of a 1:4 serial-to-parallel front end. It low-pass filters the stream with a 24-tap symmetric FIR and keeps every third filtered sample. A 960 MS/s converter stream therefore leaves as a 320 MS/s stream. Only the retained outputs are computed. Each clock carries at most two of them, and two folded multiply-accumulate units do that work on the parallel lanes, with no full-rate serial path.

Four input samples per word against a factor of three means the retained positions move across the lanes from word to word. A modulo-3 phase counter follows that motion. The output word has two slots, each with its own valid bit. Both streams use valid/ready handshakes. A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being taken in the same cycle (`out_ready` high). While the consumer holds `out_ready` low with a pending output, the output is frozen and no input is accepted.

Top module: `polyfir_dec3_x4`

## Requirements
- R1: Lane j of `in_data` (bits 16j+15 down to 16j) is input sample 4w+j of accepted word w, so lane 0 is the oldest sample and lane 3 the newest.
- R2: Count accepted samples from n=0 after reset. An output y(n) exists only for n mod 3 = 2. Its value is (sum over k=0..23 of h[k]*x[n-k] + 16384) >> 15, with an arithmetic (floor) shift, and h[k] = 512*(min(k, 23-k)+1).
- R3: A result above 32767 goes out as 32767, and a result below -32768 goes out as -32768.
- R4: After the filter span has filled, the accepted words yield 1, 1, 2 outputs in a repeating cycle, counted from the first word after reset.
- R5: No output exists for n < 23, so the first output after reset is y(23).
- R6: Outputs leave in sample order. Slot 0 (bits 15:0, valid bit 0) holds the older sample, and slot 1 (bits 31:16, valid bit 1) is valid only when slot 0 is valid.
- R7: A cycle without an accepted word changes neither the phase nor the delay line, and no new output appears in the following cycle.
- R8: While an output is valid and `out_ready` is low, `out_data` and `out_slot_valid` hold their values and `in_ready` is low. With no valid output, `in_ready` is high.
- R9: A synchronous reset clears the output valids, empties the delay line and sets the phase to 0, even when an output is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_data | input | 64 | Four signed samples, lane 0 in the low bits |
| out_slot_valid | output | 2 | Valid bit per output slot |
| out_data | output | 32 | Two signed output samples, slot 0 in the low bits |
| out_ready | input | 1 | Consumer takes the output this cycle |

## Verification
The hardest state to reach from the ports is the fill boundary word. In that word lane 0 is still too early to count as an output, while lane 3 is the first valid output, y(23). The packer must then move the later lane into slot 0. A plain stream reaches this word only as the sixth accepted word, so the stimulus resets and sends words without gaps. It checks the per-word output count and the slot order there. It then repeats the stream with input gaps and with a consumer that stalls in a fixed pattern, so the same boundary is crossed under stalls.

// File: rtl/polyfir_pkg.sv
package polyfir_pkg;
  // Symmetric triangular low-pass taps, Q15 scaled
  function automatic int tap_coef(input int k, input int taps);
    int m;
    m = (k < taps - 1 - k) ? k : taps - 1 - k;
    return 512 * (m + 1);
  endfunction
endpackage

// File: rtl/polyfir_phase.sv
module polyfir_phase #(
  parameter int LANES = 4,
  parameter int DEC   = 3,
  parameter int TAPS  = 24,
  localparam int PW   = $clog2(DEC) < 1 ? 1 : $clog2(DEC),
  localparam int FW   = $clog2(TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [LANES-1:0] lane_hit
);
  logic [PW-1:0] phase;
  logic [FW-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      fill  <= '0;
    end else if (adv) begin
      phase <= PW'((int'(phase) + LANES) % DEC);
      fill  <= (int'(fill) + LANES >= TAPS) ? FW'(TAPS) : FW'(int'(fill) + LANES);
    end
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      lane_hit[j] = ((int'(phase) + j) % DEC == DEC - 1) &&
                    (int'(fill) + j >= TAPS - 1);
    end
  end

  assert_phase_moves_R4: assert property (@(posedge clk) disable iff (rst)
    adv |=> phase != $past(phase));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase) && $stable(fill));
  assert_fill_cap_R5: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= TAPS);
endmodule

// File: rtl/polyfir_hist.sv
module polyfir_hist #(
  parameter int LANES = 4,
  parameter int TAPS  = 24,
  parameter int SW    = 16,
  localparam int EXT  = TAPS + LANES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  logic [LANES-1:0][SW-1:0]   lanes,
  output logic [EXT-1:0][SW-1:0]     ext
);
  logic [TAPS-1:0][SW-1:0] hist;

  always_comb begin
    for (int i = 0; i < TAPS; i++) ext[i] = hist[i];
    for (int j = 0; j < LANES; j++) ext[TAPS + j] = lanes[j];
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (adv) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= ext[i + LANES];
    end
  end

  assert_shift_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist));
endmodule

// File: rtl/polyfir_mac.sv
module polyfir_mac #(
  parameter int TAPS = 24,
  parameter int SW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  localparam int HALF = TAPS / 2,
  localparam int AW   = SW + 1 + CW + $clog2(HALF) + 1
) (
  input  logic [TAPS-1:0][SW-1:0] win,
  output logic [SW-1:0]           y
);
  localparam logic signed [AW-1:0] RND  = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (SW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  logic signed [AW-1:0] acc, rnd, sh;
  logic signed [SW:0]   pre;
  logic signed [CW-1:0] c;

  always_comb begin
    acc = '0;
    for (int k = 0; k < HALF; k++) begin
      pre = $signed({win[k][SW-1], win[k]}) +
            $signed({win[TAPS-1-k][SW-1], win[TAPS-1-k]});
      c   = CW'(polyfir_pkg::tap_coef(k, TAPS));
      acc = acc + (AW'(pre) * AW'(c));
    end
    rnd = acc + RND;
    sh  = rnd >>> FRAC;
    if (sh > MAXV)      y = MAXV[SW-1:0];
    else if (sh < MINV) y = MINV[SW-1:0];
    else                y = sh[SW-1:0];
  end
endmodule

// File: rtl/polyfir_dec3_x4.sv
module polyfir_dec3_x4 #(
  parameter int LANES = 4,
  parameter int DEC   = 3,
  parameter int TAPS  = 24,
  parameter int SW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 15,
  localparam int SLOTS = (LANES + DEC - 1) / DEC,
  localparam int EXT   = TAPS + LANES,
  localparam int LW    = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*SW-1:0]    in_data,
  output logic [SLOTS-1:0]       out_slot_valid,
  output logic [SLOTS*SW-1:0]    out_data,
  input  logic                   out_ready
);
  logic                          fire;
  logic [LANES-1:0]              lane_hit;
  logic [LANES-1:0][SW-1:0]      lanes;
  logic [EXT-1:0][SW-1:0]        ext;
  logic [SLOTS-1:0][LW-1:0]      slot_lane;
  logic [SLOTS-1:0]              slot_on;
  logic [SLOTS-1:0][SW-1:0]      slot_y;

  assign lanes    = in_data;
  assign in_ready = out_ready || !(|out_slot_valid);
  assign fire     = in_valid && in_ready;

  polyfir_phase #(.LANES(LANES), .DEC(DEC), .TAPS(TAPS)) phase_i (
    .clk(clk), .rst(rst), .adv(fire), .lane_hit(lane_hit));

  polyfir_hist #(.LANES(LANES), .TAPS(TAPS), .SW(SW)) hist_i (
    .clk(clk), .rst(rst), .adv(fire), .lanes(lanes), .ext(ext));

  // Pack retained lanes into slots, oldest first
  always_comb begin
    int idx;
    idx       = 0;
    slot_lane = '0;
    slot_on   = '0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_hit[j] && idx < SLOTS) begin
        slot_lane[idx] = LW'(j);
        slot_on[idx]   = 1'b1;
        idx++;
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [TAPS-1:0][SW-1:0] win;
    always_comb begin
      for (int k = 0; k < TAPS; k++) win[k] = ext[TAPS + int'(slot_lane[s]) - k];
    end
    polyfir_mac #(.TAPS(TAPS), .SW(SW), .CW(CW), .FRAC(FRAC)) mac_i (
      .win(win), .y(slot_y[s]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_slot_valid <= '0;
      out_data       <= '0;
    end else if (fire) begin
      out_slot_valid <= slot_on;
      out_data       <= slot_y;
    end else if (out_ready) begin
      out_slot_valid <= '0;
    end
  end

  assert_slot_order_R6: assert property (@(posedge clk) disable iff (rst)
    out_slot_valid[SLOTS-1] |-> out_slot_valid[0]);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (|out_slot_valid && !out_ready) |=> $stable(out_data) && $stable(out_slot_valid));
  assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !(|out_slot_valid) |-> in_ready);
  assert_idle_no_out_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !(|out_slot_valid));
endmodule

// File: tb/polyfir_dec3_x4_tb_top.sv
module polyfir_dec3_x4_tb_top;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_ready = 1;
  logic [63:0] in_data = '0;
  logic [1:0]  out_slot_valid;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  polyfir_dec3_x4 dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_slot_valid(out_slot_valid),
    .out_data(out_data), .out_ready(out_ready));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int xs [0:2047];
  int nx, ng;
  int got [0:1023];
  logic prev_fire, prev_held;
  int prev_base;
  logic [1:0]  held_v;
  logic [31:0] held_d;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int coef(input int k);
    int m;
    m = (k < 23 - k) ? k : 23 - k;
    return 512 * (m + 1);
  endfunction

  function automatic int ref_y(input int n);
    longint acc;
    acc = 0;
    for (int k = 0; k < 24; k++) acc += longint'(coef(k)) * xs[n - k];
    acc = (acc + 16384) >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic int gen(input int mode, input int n);
    case (mode)
      0: return (n == 30) ? 16384 : 0;
      1: return ((n * 7919 + 13) % 20001) - 10000;
      2: return 32767;
      default: return -32768;
    endcase
  endfunction

  function automatic int exp_cnt(input int b);
    int c;
    c = 0;
    for (int j = 0; j < 4; j++) if ((b + j) >= 23 && (b + j) % 3 == 2) c++;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    nx = 0; ng = 0; prev_fire = 0; prev_held = 0; prev_base = 0;
  endtask

  // One cycle; called at negedge
  task automatic step(input bit vld, input bit rdy, input int smode, input bit bp_on);
    bit f;
    cyc++;
    if (prev_fire && !bp_on)
      chk(int'(out_slot_valid[0]) + int'(out_slot_valid[1]) == exp_cnt(prev_base),
          "R4 outputs per word", out_slot_valid, exp_cnt(prev_base));
    if (!prev_fire && !bp_on)
      chk(out_slot_valid == 2'b00, "R7 no output after idle cycle", out_slot_valid, 0);
    if (prev_held)
      chk(out_slot_valid == held_v && out_data == held_d, "R8 output held", out_data, held_d);
    if (out_slot_valid[1] && !out_slot_valid[0])
      chk(0, "R6 slot order", out_slot_valid, 1);
    out_ready = rdy;
    in_valid  = vld;
    for (int j = 0; j < 4; j++) in_data[j*16 +: 16] = 16'(gen(smode, nx + j));
    #1;
    if (|out_slot_valid && !rdy) chk(!in_ready, "R8 ready low while stalled", in_ready, 0);
    if (!(|out_slot_valid)) chk(in_ready, "R8 ready high when empty", in_ready, 1);
    if (rdy) begin
      if (out_slot_valid[0]) begin got[ng] = int'($signed(out_data[15:0])); ng++; end
      if (out_slot_valid[1]) begin got[ng] = int'($signed(out_data[31:16])); ng++; end
    end
    f = vld && in_ready;
    prev_held = |out_slot_valid && !rdy;
    held_v = out_slot_valid; held_d = out_data;
    prev_fire = f;
    if (f) begin
      prev_base = nx;
      for (int j = 0; j < 4; j++) xs[nx + j] = gen(smode, nx + j);
      nx += 4;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run(input int words, input int smode, input int gap, input int bp, input string req);
    int sent, ne, m;
    do_reset();
    sent = 0;
    while (sent < words) begin
      bit v, r;
      v = (gap == 0) || (cyc % gap != gap - 1);
      r = (bp == 0) || (cyc % bp != 1);
      step(v, r, smode, bp != 0);
      if (prev_fire) sent++;
    end
    for (int d = 0; d < 3; d++) step(0, 1, smode, bp != 0);
    ne = 0;
    for (int n = 23; n < nx; n += 3) ne++;
    chk(ng == ne, {req, " output count"}, ng, ne);
    m = 0;
    for (int n = 23; n < nx && m < ng; n += 3) begin
      chk(got[m] == ref_y(n), req, got[m], ref_y(n));
      m++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_slot_valid == 2'b00, "R9 valids clear after reset", out_slot_valid, 0);
    chk(in_ready, "R9 ready after reset", in_ready, 1);
    for (int i = 0; i < 8; i++) step(1, 1, 1, 1'b0);
    in_valid = 1; out_ready = 0;
    @(posedge clk); @(negedge clk);
    rst = 1;
    @(posedge clk); @(negedge clk);
    chk(out_slot_valid == 2'b00, "R9 pending output dropped by reset", out_slot_valid, 0);
    rst = 0;
  endtask

  task automatic t_fill();
    int first_n;
    do_reset();
    first_n = -1;
    for (int w = 0; w < 7; w++) begin
      step(1, 1, 1, 1'b0);
      if (first_n < 0 && ng > 0) first_n = 23;
    end
    step(0, 1, 1, 1'b0);
    chk(ng > 0 && got[0] == ref_y(23), "R5 first output is y(23)", ng > 0 ? got[0] : -99999, ref_y(23));
  endtask

  initial begin
    t_reset();
    t_fill();
    run(16, 0, 0, 0, "R1 R2 impulse lane order");
    run(40, 1, 0, 0, "R2 R4 mixed stream");
    run(12, 2, 0, 0, "R3 positive saturation");
    run(12, 3, 0, 0, "R3 negative saturation");
    run(30, 1, 3, 0, "R7 input gaps");
    run(30, 1, 0, 3, "R8 output stalls");
    run(30, 1, 4, 5, "R6 R8 gaps with stalls");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule